// File: doc/BRIEF.md
# Super-pixel frame packer with payload scrambler

This block takes 30-bit super-pixel packets from a valid/ready stream and gathers up to four of them per frame period. Once every sixteen byte-clock cycles it builds a 128-bit frame and sends it to a byte-wide serializer port, one byte per cycle, so that one frame goes out per 40 MHz period. The frame begins with an 8-bit header and is followed by four 30-bit packet slots. The high nibble of the header is a fixed tag and the low nibble carries one parity bit per slot. The 120 slot bits are scrambled with an additive scrambler, which breaks up long runs of equal bits on the line. Any slot that has no packet when the frame is built is sent as an all-zero idle packet.

A sync request replaces data frames with a frame made of one configurable byte repeated. While sync is requested the block accepts no packets. Packets that were already collected stay held and go out in the first data frame after sync ends. A pulse on the frame-start output marks the header byte.

Top module: `sp_frame_packer`

## Requirements
- R1: The output repeats with a period of 16 cycles. `ser_sof` is high only in the first cycle of each period. In that cycle `ser_data` carries the frame's most significant byte, and the remaining bytes follow in order of decreasing significance. In every data frame, frame bits 127:124 equal 4'h5.
- R2: Packets are placed in arrival order. Slot i (i = 0..3) holds the i-th packet accepted for the frame, before scrambling, at frame bits [119-30i : 90-30i]. Slot 0 therefore sits directly after the header.
- R3: Frame bit 120+i is the XOR of the 30 unscrambled bits of slot i. This parity is 0 for an idle slot.
- R4: The 7-bit scrambler state S is set to 7'h7F at reset. For each of the 120 payload bits, taken from bit 119 down to bit 0, the key bit k = S[6]^S[5] is XORed into that bit and then S becomes {S[5:0],k}. The state carries over from one data frame to the next and does not change during sync frames. Header bits are not scrambled.
- R5: Any slot that holds no packet when the frame is built is all zeros before scrambling. A frame with no packets is therefore the header 8'h50 followed by the bare keystream.
- R6: `in_ready` is high exactly when `sync_en` is low and fewer than four packets have been collected for the frame being built. A packet accepted in the 16th cycle of a period goes into the frame built at the end of that cycle.
- R7: If `sync_en` is high in the 16th cycle of a period, the next frame consists of `sync_byte` sixteen times, with no header and no scrambling. Packets already collected are kept and placed in the next data frame.
- R8: After reset the first frame is 8'h50 followed by fifteen zero bytes, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, 16 cycles per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A super-pixel packet is offered |
| in_data | input | 30 | Super-pixel packet |
| in_ready | output | 1 | Packet accepted when high together with in_valid |
| sync_en | input | 1 | Request sync frames instead of data frames |
| sync_byte | input | 8 | Byte repeated through a sync frame |
| ser_data | output | 8 | Byte to the serializer |
| ser_sof | output | 1 | High on the first byte of each frame |

## Verification
The hardest case to reach is a sync request that starts partway through a frame period while packets are already held. Those packets must survive the sync frame, and the scrambler state must stay frozen until they go out. Directed frames produce this by raising `sync_en` halfway through a period after random packet traffic. They also place a single packet exactly in the last cycle of a period. Random segments then vary the offered load between empty and saturated.

// File: rtl/sp_frame_packer.sv
module sp_frame_packer #(
  parameter int PKT_W = 30,
  parameter int NSLOT = 4,
  parameter logic [3:0] HDR_TAG = 4'h5,
  parameter logic [6:0] SCR_SEED = 7'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PKT_W-1:0] in_data,
  output logic             in_ready,
  input  logic             sync_en,
  input  logic [7:0]       sync_byte,
  output logic [7:0]       ser_data,
  output logic             ser_sof
);
  localparam int PAY_W = PKT_W * NSLOT;
  localparam int FRM_W = 4 + NSLOT + PAY_W;
  localparam int NBYTE = FRM_W / 8;
  localparam int CW = $clog2(NBYTE);
  localparam int FW = $clog2(NSLOT + 1);
  localparam int SW = $clog2(NSLOT);
  localparam logic [FRM_W-1:0] IDLE_FRM = {HDR_TAG, {(FRM_W-4){1'b0}}};

  logic [CW-1:0]             cnt;
  logic [FW-1:0]             fill;
  logic [NSLOT-1:0][PKT_W-1:0] slot, slot_n;
  logic [6:0]                lfsr, lfsr_n;
  logic [FRM_W-1:0]          shreg;
  logic                      out_sync;
  logic [PAY_W-1:0]          pay_plain, pay_scr;
  logic [NSLOT-1:0]          par;
  logic                      last, take;

  assign last     = (cnt == CW'(NBYTE - 1));
  assign in_ready = !sync_en && (fill < FW'(NSLOT));
  assign take     = in_valid && in_ready;
  assign ser_data = shreg[FRM_W-1 -: 8];
  assign ser_sof  = (cnt == '0);

  always_comb begin
    logic [6:0] st;
    logic       kb;
    slot_n = slot;
    if (take) slot_n[fill[SW-1:0]] = in_data;
    for (int i = 0; i < NSLOT; i++) begin
      pay_plain[PAY_W-1-PKT_W*i -: PKT_W] = slot_n[i];
      par[i] = ^slot_n[i];
    end
    st = lfsr;
    for (int k = 0; k < PAY_W; k++) begin
      kb = st[6] ^ st[5];
      pay_scr[PAY_W-1-k] = pay_plain[PAY_W-1-k] ^ kb;
      st = {st[5:0], kb};
    end
    lfsr_n = st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      fill     <= '0;
      slot     <= '0;
      lfsr     <= SCR_SEED;
      shreg    <= IDLE_FRM;
      out_sync <= 1'b0;
    end else begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (last && sync_en) begin
        shreg    <= {NBYTE{sync_byte}};
        out_sync <= 1'b1;
        slot     <= slot_n;
      end else if (last) begin
        shreg    <= {HDR_TAG, par, pay_scr};
        out_sync <= 1'b0;
        lfsr     <= lfsr_n;
        slot     <= '0;
        fill     <= '0;
      end else begin
        shreg <= shreg << 8;
        slot  <= slot_n;
        fill  <= fill + FW'(take);
      end
    end
  end
endmodule

// File: rtl/sp_frame_packer_chk.sv
module sp_frame_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       sync_en,
  input logic [7:0] ser_data,
  input logic       ser_sof,
  input logic       out_sync
);
  logic [4:0] gap;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      gap  <= ser_sof ? 5'd0 : gap + 5'd1;
      seen <= seen | ser_sof;
    end
  end

  AST_SOF_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (ser_sof && seen) |-> gap == 5'd15); // R1
  AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ser_sof |=> !ser_sof); // R1
  AST_HEADER_TAG: assert property (@(posedge clk) disable iff (!rst_n) (ser_sof && !out_sync) |-> ser_data[7:4] == 4'h5); // R1
  AST_SYNC_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n) sync_en |-> !in_ready); // R6
  AST_SYNC_FLAT: assert property (@(posedge clk) disable iff (!rst_n) (out_sync && !ser_sof && seen) |-> ser_data == $past(ser_data)); // R7
endmodule

bind sp_frame_packer sp_frame_packer_chk i_chk (.*);

// File: tb/test_sp_frame_packer.sv
module test_sp_frame_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [29:0] in_data = '0;
  logic        in_ready;
  logic        sync_en = 1'b0;
  logic [7:0]  sync_byte = '0;
  logic [7:0]  ser_data;
  logic        ser_sof;

  int n_chk = 0, n_fail = 0, phase = 0;
  bit done = 1'b0;
  logic [29:0]  b_slot [4];
  int           b_fill = 0;
  logic [6:0]   b_lfsr = 7'h7F;
  logic [127:0] exp_frm;
  string        exp_tag;

  always #10ns clk = ~clk;

  sp_frame_packer i_sp_frame_packer (.*);

  task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (phase %0d)", r, act, exp, phase);
    end
  endtask

  function automatic logic [127:0] build(input bit need_slots);
    logic [119:0] pl;
    logic [3:0]   p;
    logic         kb;
    pl = '0;
    for (int i = 0; i < 4; i++) begin
      logic [29:0] s;
      s = (i < b_fill) ? b_slot[i] : 30'd0;
      pl[119-30*i -: 30] = s;
      p[i] = ^s;
    end
    for (int k = 0; k < 120; k++) begin
      kb = b_lfsr[6] ^ b_lfsr[5];
      pl[119-k] ^= kb;
      b_lfsr = {b_lfsr[5:0], kb};
    end
    return {4'h5, p, pl};
  endfunction

  task automatic run_frames(input int nfr, input int pct, input int sync_from,
                            input logic [7:0] sb, input bit late_only);
    for (int f = 0; f < nfr; f++) begin
      for (int c = 0; c < 16; c++) begin
        bit v, rdy;
        chk(ser_sof == (phase == 0), "R1", 128'(ser_sof), 128'(phase == 0));
        if (phase == 0) begin
          chk(ser_data == exp_frm[127:120], (exp_tag == "R7" || exp_tag == "R8") ? exp_tag : "R3",
              128'(ser_data), 128'(exp_frm[127:120]));
          if (exp_tag != "R7")
            chk(ser_data[7:4] == 4'h5, "R1", 128'(ser_data[7:4]), 128'h5);
        end else
          chk(ser_data == exp_frm[127-8*phase -: 8], exp_tag, 128'(ser_data), 128'(exp_frm[127-8*phase -: 8]));
        v = late_only ? (phase == 15) : ($urandom_range(99) < pct);
        in_valid  = v;
        in_data   = $urandom();
        sync_en   = (phase >= sync_from);
        sync_byte = sb;
        #1;
        rdy = !sync_en && (b_fill < 4);
        chk(in_ready == rdy, "R6", 128'(in_ready), 128'(rdy));
        if (v && rdy) begin
          b_slot[b_fill] = in_data;
          b_fill++;
        end
        if (phase == 15) begin
          if (sync_en) begin
            exp_frm = {16{sb}};
            exp_tag = "R7";
          end else begin
            exp_tag = (b_fill == 0) ? "R5" : (b_fill == 4) ? "R2" : "R4";
            exp_frm = build(1'b1);
            b_fill = 0;
          end
        end
        @(posedge clk);
        phase = (phase + 1) % 16;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_frm = {8'h50, 120'd0};
    exp_tag = "R8";
    chk(in_ready == 1'b1, "R8", 128'(in_ready), 128'd1);
    run_frames(2, 0, 16, 8'h00, 1'b0);        // R5 idle frames
    run_frames(3, 100, 16, 8'h00, 1'b0);      // R2 full frames
    run_frames(2, 0, 16, 8'h00, 1'b1);        // R6 packet in last cycle
    run_frames(1, 60, 8, 8'hA5, 1'b0);        // R7 sync mid-period with held packets
    run_frames(2, 60, 0, 8'h3C, 1'b0);        // R7 sync frames, scrambler frozen
    run_frames(1, 0, 16, 8'h00, 1'b0);        // R7 held packets emitted
    for (int s = 0; s < 40; s++)
      run_frames(3, $urandom_range(100), ($urandom_range(9) == 0) ? $urandom_range(15) : 16,
                 8'($urandom()), 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule